// File: doc/BRIEF.md
# Shared-Space Memory-Mapped Host Arbiter

This block lets several internal access ports reach one byte-addressed memory-mapped host bus. Each port asks for single-beat reads or writes by element index, and every port has its own element size (1, 2 or 4 bytes). A port turns its index into a byte address by shifting it left by log2 of its element size. It also works out which byte lanes it uses, and where its write data and read data sit on the wide data bus. Requesting ports take turns on the bus in round-robin order.

One instance serves one address space. Ports that target a different address space are wired to a separate instance with its own bus. The agent can stall a command with a wait-request input; the held command then stays frozen on the bus. Read data comes back in one of two ways, chosen at build time. With a latency of zero the agent marks returned data with a data-valid strobe. With a non-zero latency the data arrives a fixed number of cycles after the read is accepted. In both cases a small tag queue sends each returned word to the port that issued the read, in issue order.

Top module: `mm_shared_host`

## Requirements
- R1: The bus address of a command is the port's element index shifted left by log2 of that port's element size, cut to the address width. With the default element sizes, index 0x0006 gives 0x0018 on the 4-byte port (port 0) and 0x0006 on the 1-byte port (port 2). Index 3 on the 2-byte port (port 1) gives 0x0006.
- R2: The byte enables hold one set bit per element byte, shifted up by the low two address bits (bit k is lane k, data bits 8k+7..8k). Write data is cut to the element width and placed on those lanes. Examples: a 2-byte write to address 6 enables 4'b1100, and a 1-byte write to address 6 enables 4'b0100.
- R3: At most one port sees req_ready in any cycle, and bus_read and bus_write are never high together.
- R4: While bus_waitreq is high during a command, the next cycle shows the same command, with the same address, byte enables, write data and direction.
- R5: Grants rotate. After port k is granted, the next grant goes to the first requesting port found after k in cyclic order. After reset, port 0 has first priority. req_ready is never given to a port whose req_valid is low.
- R6: Each read response appears on rsp_valid of the port that issued the read, in issue order. Its data is the bus word shifted down by 8 times the low two address bits and cut to the element width.
- R7: With FIXED_LAT = 0, a response is produced in exactly the cycles where bus_rdvalid is high.
- R8: With FIXED_LAT = L > 0, the response to a read accepted in cycle c appears in cycle c+L and takes bus_rdata from that cycle. bus_rdvalid has no effect.
- R9: A write completes when the bus accepts it and produces no response on any port.
- R10: When TAG_DEPTH reads have been granted and not yet answered, no port receives req_ready.
- R11: While reset is held, bus_read, bus_write, req_ready and rsp_valid are all low, even with every req_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NPORTS | Per-port request present |
| req_ready | output | NPORTS | Per-port request taken on this edge |
| req_write | input | NPORTS | Per-port direction, 1 = write |
| req_index | input | NPORTS*IDX_W | Per-port element index |
| req_wdata | input | NPORTS*DATA_W | Per-port write element (low bits used) |
| rsp_valid | output | NPORTS | Per-port read response strobe |
| rsp_data | output | NPORTS*DATA_W | Per-port read element, zero-extended |
| bus_addr | output | ADDR_W | Byte address |
| bus_read | output | 1 | Read command |
| bus_write | output | 1 | Write command |
| bus_byteen | output | DATA_W/8 | Byte lane enables |
| bus_wdata | output | DATA_W | Lane-aligned write data |
| bus_waitreq | input | 1 | Agent stall |
| bus_rdata | input | DATA_W | Read data from agent |
| bus_rdvalid | input | 1 | Read data strobe (variable-latency build only) |

## Verification
Two builds run side by side: one with strobed variable latency and one with a fixed latency of two cycles. Each faces an agent that stalls at random. At the start, all three ports request together, each with a set index. This separates correct per-port scaling from a shared shift, and checks that arbitration starts from port 0 after reset. After that, random indices, directions and data land on every lane offset. Random response timing, random bursts of reads and random stalls then fill the tag queue, check the rotation order, keep stalled commands frozen, and catch responses that go to the wrong port, come out of order or arrive at the wrong cycle. The fixed-latency build drives bus_rdvalid with noise, so a design that listens to the strobe fails there.

// File: rtl/mmh_pkg.sv
package mmh_pkg;

  // Bytes in one element given log2 of its size.
  function automatic int elem_bytes(input int sz_log2);
    return 1 << sz_log2;
  endfunction

  // Cyclic successor used by the rotating arbiter.
  function automatic int wrap_add(input int base, input int off, input int n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/mmh_port_lane.sv
module mmh_port_lane
  import mmh_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SZ     = 2
) (
  input  logic [IDX_W-1:0]               index,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [$clog2(DATA_W/8)-1:0]    rd_lane,
  input  logic [DATA_W-1:0]              rdata,
  output logic [ADDR_W-1:0]              addr,
  output logic [DATA_W/8-1:0]            byteen,
  output logic [$clog2(DATA_W/8)-1:0]    lane,
  output logic [DATA_W-1:0]              wdata_out,
  output logic [DATA_W-1:0]              rdata_out
);
  localparam int BE_W   = DATA_W / 8;
  localparam int LANE_W = $clog2(BE_W);
  localparam int NB     = elem_bytes(SZ);
  localparam int WIDE_W = ADDR_W + IDX_W;
  localparam logic [BE_W-1:0]   BE_BASE = BE_W'((1 << NB) - 1);
  localparam logic [DATA_W-1:0] DMASK   = {DATA_W{1'b1}} >> (DATA_W - 8 * NB);

  logic [WIDE_W-1:0] wide;

  always_comb begin
    wide      = WIDE_W'(index) << SZ;
    addr      = wide[ADDR_W-1:0];
    lane      = addr[LANE_W-1:0];
    byteen    = BE_BASE << lane;
    wdata_out = (wdata & DMASK) << {lane, 3'b000};
    rdata_out = (rdata >> {rd_lane, 3'b000}) & DMASK;
  end
endmodule

// File: rtl/mmh_rr_arb.sv
module mmh_rr_arb
  import mmh_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          allow,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] win
);
  logic [IW-1:0] last_q, last_d;
  logic          hit;

  always_comb begin
    gnt = '0;
    win = '0;
    hit = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = wrap_add(int'(last_q), k, N);
      if (allow && !hit && req[j]) begin
        gnt[j] = 1'b1;
        win    = IW'(j);
        hit    = 1'b1;
      end
    end
    last_d = hit ? win : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/mmh_tag_fifo.sv
module mmh_tag_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = push ? PW'((int'(wp_q) + 1) % DEPTH) : wp_q;
    rp_d  = pop  ? PW'((int'(rp_q) + 1) % DEPTH) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/mm_shared_host.sv
module mm_shared_host #(
  parameter int NPORTS    = 3,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 16,
  parameter int FIXED_LAT = 0,
  parameter int TAG_DEPTH = 4,
  parameter logic [2*NPORTS-1:0] PORT_SZ = {2'd0, 2'd1, 2'd2}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        req_valid,
  output logic [NPORTS-1:0]        req_ready,
  input  logic [NPORTS-1:0]        req_write,
  input  logic [NPORTS*IDX_W-1:0]  req_index,
  input  logic [NPORTS*DATA_W-1:0] req_wdata,
  output logic [NPORTS-1:0]        rsp_valid,
  output logic [NPORTS*DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic                     bus_read,
  output logic                     bus_write,
  output logic [DATA_W/8-1:0]      bus_byteen,
  output logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_waitreq,
  input  logic [DATA_W-1:0]        bus_rdata,
  input  logic                     bus_rdvalid
);
  localparam int BE_W   = DATA_W / 8;
  localparam int LANE_W = $clog2(BE_W);
  localparam int PID_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int TAG_W  = PID_W + LANE_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // Per-port scaling and lane placement.
  logic [ADDR_W-1:0] p_addr [NPORTS];
  logic [BE_W-1:0]   p_be   [NPORTS];
  logic [LANE_W-1:0] p_lane [NPORTS];
  logic [DATA_W-1:0] p_wd   [NPORTS];
  logic [TAG_W-1:0]  tag_out;
  logic [PID_W-1:0]  tag_pid;
  logic [LANE_W-1:0] tag_lane;

  assign tag_pid  = tag_out[TAG_W-1:LANE_W];
  assign tag_lane = tag_out[LANE_W-1:0];

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    mmh_port_lane #(
      .IDX_W (IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SZ    (int'(PORT_SZ[2*i +: 2]))
    ) u_lane (
      .index     (req_index[i*IDX_W +: IDX_W]),
      .wdata     (req_wdata[i*DATA_W +: DATA_W]),
      .rd_lane   (tag_lane),
      .rdata     (bus_rdata),
      .addr      (p_addr[i]),
      .byteen    (p_be[i]),
      .lane      (p_lane[i]),
      .wdata_out (p_wd[i]),
      .rdata_out (rsp_data[i*DATA_W +: DATA_W])
    );
  end

  // Command slot and arbitration.
  logic              cmd_vld_q, cmd_vld_d, cmd_wr_q, cmd_wr_d;
  logic [ADDR_W-1:0] cmd_addr_q, cmd_addr_d;
  logic [BE_W-1:0]   cmd_be_q, cmd_be_d;
  logic [DATA_W-1:0] cmd_wd_q, cmd_wd_d;
  logic              slot_free, allow, load_en, tag_full, tag_empty;
  logic              accept_rd, ret, tag_push;
  logic [NPORTS-1:0] gnt;
  logic [PID_W-1:0]  win;

  assign slot_free = !cmd_vld_q || !bus_waitreq;
  assign allow     = rst_s_n && slot_free && !tag_full;

  mmh_rr_arb #(.N(NPORTS), .IW(PID_W)) u_arb (
    .clk(clk), .rst_n(rst_s_n), .allow(allow), .req(req_valid),
    .gnt(gnt), .win(win)
  );

  assign req_ready = gnt;
  assign load_en   = |gnt;
  assign tag_push  = load_en && !req_write[win];

  always_comb begin
    cmd_vld_d  = slot_free ? load_en : cmd_vld_q;
    cmd_wr_d   = req_write[win];
    cmd_addr_d = p_addr[win];
    cmd_be_d   = p_be[win];
    cmd_wd_d   = p_wd[win];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cmd_vld_q <= 1'b0;
    else          cmd_vld_q <= cmd_vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      cmd_wr_q   <= cmd_wr_d;
      cmd_addr_q <= cmd_addr_d;
      cmd_be_q   <= cmd_be_d;
      cmd_wd_q   <= cmd_wd_d;
    end
  end

  assign bus_read   = cmd_vld_q && !cmd_wr_q;
  assign bus_write  = cmd_vld_q && cmd_wr_q;
  assign bus_addr   = cmd_addr_q;
  assign bus_byteen = cmd_be_q;
  assign bus_wdata  = cmd_wd_q;
  assign accept_rd  = bus_read && !bus_waitreq;

  // Read return timing.
  if (FIXED_LAT == 0) begin : g_var
    assign ret = bus_rdvalid;
  end else begin : g_fix
    logic [FIXED_LAT-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) lat_q <= '0;
      else          lat_q <= (lat_q << 1) | FIXED_LAT'(accept_rd);
    end
    assign ret = lat_q[FIXED_LAT-1];
  end

  mmh_tag_fifo #(.W(TAG_W), .DEPTH(TAG_DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_s_n), .push(tag_push), .din({win, p_lane[win]}),
    .pop(ret), .dout(tag_out), .full(tag_full), .empty(tag_empty)
  );

  always_comb begin
    for (int i = 0; i < NPORTS; i++)
      rsp_valid[i] = rst_s_n && ret && (tag_pid == PID_W'(i));
  end

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((bus_read || bus_write) && bus_waitreq) |=>
      ($stable(bus_addr) && $stable(bus_byteen) && $stable(bus_wdata) &&
       $stable(bus_read) && $stable(bus_write)));
  assert_ready_only_valid_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_ready & ~req_valid) == '0);
  assert_no_grant_full_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    tag_full |-> (req_ready == '0));
  assert_rsp_owed_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|rsp_valid) |-> !tag_empty);
endmodule

// File: tb/tb_mm_shared_host.sv
module tb_mm_shared_host;
  localparam int NP = 3, DW = 32, AW = 16, IW = 16, DEPTH = 4;
  localparam logic [2*NP-1:0] SZV = {2'd0, 2'd1, 2'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic stop_req = 1'b0;
  int   cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int szl(input int p);
    return int'(SZV[2*p +: 2]);
  endfunction
  function automatic logic [AW-1:0] exp_addr(input int p, input logic [IW-1:0] idx);
    logic [31:0] w;
    w = 32'(idx) << szl(p);
    return w[AW-1:0];
  endfunction
  function automatic logic [3:0] exp_be(input int p, input logic [AW-1:0] a);
    logic [3:0] m;
    m = 4'((1 << (1 << szl(p))) - 1);
    return m << a[1:0];
  endfunction
  function automatic logic [DW-1:0] dmask(input int p);
    logic [63:0] m;
    m = (64'd1 << (8 * (1 << szl(p)))) - 64'd1;
    return m[DW-1:0];
  endfunction
  function automatic logic [DW-1:0] exp_wd(input int p, input logic [DW-1:0] d, input logic [AW-1:0] a);
    return (d & dmask(p)) << (8 * a[1:0]);
  endfunction
  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (32'h9E3779B1 * 32'(a[AW-1:2])) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [DW-1:0] exp_rd(input int p, input logic [AW-1:0] a);
    return (mem_word(a) >> (8 * a[1:0])) & dmask(p);
  endfunction
  function automatic int exp_rr(input logic [NP-1:0] v, input int last);
    for (int k = 1; k <= NP; k++) if (v[(last + k) % NP]) return (last + k) % NP;
    return -1;
  endfunction

  for (genvar g = 0; g < 2; g++) begin : cfg
    localparam int LAT = (g == 0) ? 0 : 2;
    logic [NP-1:0] req_valid, req_write, req_ready, rsp_valid;
    logic [NP*IW-1:0] req_index;
    logic [NP*DW-1:0] req_wdata, rsp_data;
    logic [AW-1:0] bus_addr;
    logic bus_read, bus_write, bus_waitreq, bus_rdvalid;
    logic [3:0] bus_be;
    logic [DW-1:0] bus_wdata, bus_rdata;

    mm_shared_host #(.NPORTS(NP), .DATA_W(DW), .ADDR_W(AW), .IDX_W(IW),
      .FIXED_LAT(LAT), .TAG_DEPTH(DEPTH), .PORT_SZ(SZV)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_addr(bus_addr),
      .bus_read(bus_read), .bus_write(bus_write), .bus_byteen(bus_be),
      .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata),
      .bus_rdvalid(bus_rdvalid));

    int n_chk = 0, n_bad = 0, outst = 0, last_w = NP - 1, ncmd = 0;
    logic idle = 1'b0;
    logic [NP-1:0] took = '0;
    int nreq [NP];
    logic [AW-1:0] ecq_a[$]; logic [3:0] ecq_be[$]; logic [DW-1:0] ecq_wd[$];
    logic ecq_wr[$]; int ecq_p[$];
    int erq_p[$]; logic [DW-1:0] erq_d[$]; int erq_due[$];
    logic [AW-1:0] aq_a[$]; int aq_due[$];
    logic prev_hold = 1'b0;
    logic [AW-1:0] pv_a; logic [3:0] pv_be; logic [DW-1:0] pv_wd; logic pv_rd, pv_wr;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s (cfg %0d, cycle %0d): actual %h expected %h", tag, g, cyc, act, exp);
      end
    endtask

    initial begin
      for (int p = 0; p < NP; p++) nreq[p] = 0;
      req_valid = '1; req_write = '0; req_index = '0; req_wdata = '0;
      bus_waitreq = 1'b0; bus_rdvalid = 1'b0; bus_rdata = '0;
      void'($urandom(1234 + g));
      repeat (2) begin
        @(negedge clk); #2;
        chk(!bus_read && !bus_write, "R11 bus idle in reset", {bus_read, bus_write}, 0);
        chk(req_ready == '0, "R11 no ready in reset", req_ready, 0);
        chk(rsp_valid == '0, "R11 no response in reset", rsp_valid, 0);
      end
      req_valid = '0;
      wait (run);
      forever begin
        @(negedge clk);
        // port stimulus
        for (int p = 0; p < NP; p++) begin
          if (!req_valid[p] || took[p]) begin
            took[p] = 1'b0;
            if (nreq[p] == 0) begin
              req_valid[p] = 1'b1;
              req_write[p] = (p != 0);
              req_index[p*IW +: IW] = (p == 1) ? 16'd3 : 16'd6;
              req_wdata[p*DW +: DW] = (p == 1) ? 32'h1234ABCD : 32'h000000AB;
              nreq[p]++;
            end else if (!stop_req && ($urandom % 100) < 60) begin
              req_valid[p] = 1'b1;
              req_write[p] = 1'($urandom % 2);
              req_index[p*IW +: IW] = IW'($urandom);
              req_wdata[p*DW +: DW] = $urandom;
              nreq[p]++;
            end else req_valid[p] = 1'b0;
          end
        end
        // agent
        bus_waitreq = (($urandom % 4) == 0);
        if (LAT == 0) begin
          if (aq_a.size() > 0 && ($urandom % 3) != 0) begin
            bus_rdvalid = 1'b1; bus_rdata = mem_word(aq_a.pop_front());
          end else begin
            bus_rdvalid = 1'b0; bus_rdata = $urandom;
          end
        end else begin
          bus_rdvalid = 1'($urandom % 2);
          if (aq_a.size() > 0 && aq_due[0] == cyc) begin
            bus_rdata = mem_word(aq_a.pop_front()); void'(aq_due.pop_front());
          end else bus_rdata = $urandom;
        end
        #2;
        // handshakes
        chk($countones(req_ready) <= 1, "R3 single ready", req_ready, 0);
        if (outst >= DEPTH) chk(req_ready == '0, "R10 no grant while tags full", req_ready, 0);
        if (req_ready != '0) begin
          int w;
          w = 0;
          for (int p = 0; p < NP; p++) if (req_ready[p]) w = p;
          chk((req_ready & ~req_valid) == '0, "R5 ready only to requester", req_ready, req_valid);
          chk(w == exp_rr(req_valid, last_w), "R5 rotation order", w, exp_rr(req_valid, last_w));
          begin
            logic [AW-1:0] a;
            a = exp_addr(w, req_index[w*IW +: IW]);
            ecq_a.push_back(a); ecq_be.push_back(exp_be(w, a));
            ecq_wd.push_back(exp_wd(w, req_wdata[w*DW +: DW], a));
            ecq_wr.push_back(req_write[w]); ecq_p.push_back(w);
          end
          last_w = w; took[w] = 1'b1;
          if (!req_write[w]) outst++;
        end
        // bus commands
        if (bus_read || bus_write) begin
          chk(!(bus_read && bus_write), "R3 exclusive command", {bus_read, bus_write}, 0);
          if (prev_hold) begin
            chk(bus_addr == pv_a && bus_be == pv_be && bus_read == pv_rd && bus_write == pv_wr &&
                (pv_rd || bus_wdata == pv_wd), "R4 held command", bus_addr, pv_a);
          end
          if (!bus_waitreq) begin
            if (ecq_a.size() == 0) chk(0, "R3 command without grant", bus_addr, 0);
            else begin
              logic [AW-1:0] ea; logic [3:0] eb; logic [DW-1:0] ed; logic ew; int ep;
              ea = ecq_a.pop_front(); eb = ecq_be.pop_front(); ed = ecq_wd.pop_front();
              ew = ecq_wr.pop_front(); ep = ecq_p.pop_front();
              chk(bus_addr == ea, "R1 byte address", bus_addr, ea);
              chk(bus_be == eb, "R2 byte enables", bus_be, eb);
              chk(bus_write == ew, "R3 command direction", bus_write, ew);
              if (ew) chk(bus_wdata == ed, "R2 write lane data", bus_wdata, ed);
              if (ncmd == 0) chk(bus_addr == 16'h0018, "R1 4-byte index 6", bus_addr, 16'h0018);
              if (ncmd == 1) chk(bus_be == 4'b1100 && bus_wdata == 32'hABCD0000,
                                 "R2 2-byte write at lane 2", {bus_be, bus_wdata}, {4'b1100, 32'hABCD0000});
              if (ncmd == 2) chk(bus_addr == 16'h0006 && bus_be == 4'b0100 && bus_wdata == 32'h00AB0000,
                                 "R1 1-byte index 6", {bus_addr, bus_be, bus_wdata}, {16'h0006, 4'b0100, 32'h00AB0000});
              ncmd++;
              if (!ew) begin
                aq_a.push_back(bus_addr); aq_due.push_back(cyc + LAT);
                erq_p.push_back(ep); erq_d.push_back(exp_rd(ep, bus_addr)); erq_due.push_back(cyc + LAT);
              end
            end
          end
          prev_hold = bus_waitreq;
          pv_a = bus_addr; pv_be = bus_be; pv_wd = bus_wdata; pv_rd = bus_read; pv_wr = bus_write;
        end else prev_hold = 1'b0;
        // responses
        if (rsp_valid != '0) begin
          if (LAT == 0) chk(bus_rdvalid, "R7 response only on strobe", rsp_valid, 0);
          if (erq_p.size() == 0) chk(0, "R9 response with no read owed", rsp_valid, 0);
          else begin
            int ep; logic [DW-1:0] ed; int due;
            ep = erq_p.pop_front(); ed = erq_d.pop_front(); due = erq_due.pop_front();
            chk(rsp_valid == NP'(1 << ep), "R6 response port", rsp_valid, NP'(1 << ep));
            chk(rsp_data[ep*DW +: DW] == ed, "R6 response data", rsp_data[ep*DW +: DW], ed);
            if (LAT > 0) chk(due == cyc, "R8 fixed latency timing", cyc, due);
            outst--;
          end
        end else begin
          if (LAT == 0 && bus_rdvalid) chk(0, "R7 strobe without response", 0, 1);
          if (LAT > 0 && erq_due.size() > 0 && erq_due[0] == cyc) chk(0, "R8 missing response", 0, 1);
        end
        idle = (req_valid == '0) && (ecq_a.size() == 0) && (erq_p.size() == 0);
      end
    end
  end

  initial begin
    int tot_chk, tot_bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;
    repeat (4000) @(posedge clk);
    stop_req = 1'b1;
    while (!(cfg[0].idle && cfg[1].idle) && cyc < 20000) @(posedge clk);
    tot_chk = cfg[0].n_chk + cfg[1].n_chk;
    tot_bad = cfg[0].n_bad + cfg[1].n_bad;
    if (cyc >= 20000) begin
      tot_chk++; tot_bad++;
      $display("FAIL watchdog: actual cycle %0d expected drain before 20000", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", tot_chk, tot_bad);
    $finish;
  end
endmodule